// File: doc/BRIEF.md
# Scan Chain Flush Tester

This block checks that a scan chain shifts correctly before any structural test is loaded through it. When started, it puts the chain into shift mode by driving its test-control output low. It then feeds a repeating two-zeros, two-ones stream into the chain input for exactly as many clocks as the chain is long plus four. Over that run, every flip-flop in the chain sees a 0-to-0, 0-to-1, 1-to-1 and 1-to-0 transition.

The tester looks only at the chain output. Once the first driven bit can have travelled the full configured length, it compares each arriving bit with the bit it drove that many clocks earlier. That gives four compared bits per flush. The first disagreement sets a sticky failure flag and records the 0-based flush cycle in which it was seen. A clean run raises a pass flag instead. Downstream scan sequencing may begin only while the pass flag is high. The chain length is taken from a configuration input when the flush is started.

Top module: `scan_flush_tester`

## Requirements
- R1: During reset (`rst_n` low at a clock edge), and in the cycle after it, `busy`, `done`, `chain_ok`, `chain_bad` and `scan_in` are 0, `fail_idx` is 0, and `test_ctrl` is 1 (normal mode).
- R2: A `start` seen at an edge while idle makes `busy` high and `test_ctrl` low (scan mode) for exactly `chain_len`+4 consecutive cycles. The length is sampled at that edge and must be at least 1.
- R3: In flush cycle k (k = 0 for the first busy cycle), `scan_in` equals bit 1 of k, which gives the repeating sequence 0,0,1,1. Outside a flush, `scan_in` is 0.
- R4: In each flush cycle k with k ≥ `chain_len`, `scan_out` is sampled at the end of the cycle and compared with the bit driven in cycle k−`chain_len`. If all four comparisons agree, `chain_ok` is 1 from the `done` cycle until the next accepted start or reset.
- R5: At the first disagreeing comparison, `chain_bad` is set and `fail_idx` takes that k. Later disagreements in the same flush change neither. `chain_ok` and `chain_bad` are never both 1.
- R6: `done` is high for exactly one cycle: the cycle right after the last flush cycle. Both `busy` and `test_ctrl` return to idle levels in that same cycle.
- R7: A `start` while `busy` is ignored. The running flush keeps its count, length and verdict.
- R8: A `start` during the `done` cycle is accepted, because the block is idle then. It clears `chain_ok`, `chain_bad` and `fail_idx` and begins a new flush.
- R9: Reset during a flush aborts it. `busy` drops, no `done` is produced, and `test_ctrl` returns to 1.
- R10: Each of these faults gives `chain_bad` with the first failing k: a chain stuck at 0, a chain stuck at 1, an inverting chain, and a chain one stage longer or one stage shorter than configured. For the longer chain, the stage contents before the flush are taken as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a flush; taken only when idle |
| chain_len | input | LEN_W | Number of flip-flops in the chain (at least 1) |
| scan_out | input | 1 | Last stage of the chain under test |
| busy | output | 1 | Flush in progress |
| done | output | 1 | One-cycle end-of-flush pulse |
| test_ctrl | output | 1 | Chain mode: 0 shift, 1 normal |
| scan_in | output | 1 | Bit fed into the first chain stage |
| chain_ok | output | 1 | Last flush passed; scan sequencing permitted |
| chain_bad | output | 1 | Sticky failure flag for the current or last flush |
| fail_idx | output | LEN_W+1 | Flush cycle of the first mismatch |

## Verification
The end of one flush and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start` during the `done` cycle of a failing flush. It then expects the next cycle to be flush cycle 0, with the stale failure cleared and the second verdict computed freshly. A second coincidence is a `start` landing mid-flush, alongside a counting cycle. This is judged by the flush still lasting `chain_len`+4 cycles with an unchanged verdict. Expected failure indices come from a behavioural chain model that has fault modes and a settable true length.

// File: rtl/flush_pkg.sv
// Shared types for the scan chain flush tester.
package flush_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } flush_state_t;
endpackage

// File: rtl/flush_ctrl.sv
// Flush sequencer: accepts start only when idle, latches the chain length,
// counts flush cycles 0..len+3 and pulses done after the last one.
// Assumes the latched length is at least 1.
module flush_ctrl #(
    parameter int LEN_W = 6,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] chain_len,
    output logic             busy,
    output logic             accept,
    output logic             last,
    output logic             done,
    output logic [CNT_W-1:0] cyc,
    output logic [CNT_W-1:0] len_ext
);
    import flush_pkg::*;

    flush_state_t     state;
    logic [LEN_W-1:0] len_q;

    assign busy    = (state == ST_RUN);
    assign accept  = start && !busy;
    assign len_ext = {1'b0, len_q};
    assign last    = busy && (cyc == len_ext + CNT_W'(3));

    // State, cycle counter, latched length and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cyc   <= '0;
            len_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state <= ST_RUN;
                cyc   <= '0;
                len_q <= chain_len;
            end else if (last) begin
                state <= ST_IDLE;
                done  <= 1'b1;
            end else if (busy) begin
                cyc <= cyc + CNT_W'(1);
            end
        end
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> done && !busy);
    p_run_continues_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !last |=> busy && (cyc == $past(cyc) + CNT_W'(1)));
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(len_q));
endmodule

// File: rtl/flush_pattern.sv
// Pattern source and reference: drives the 0,0,1,1 stream from the cycle
// count and derives the bit expected at the chain output, which is the
// bit driven len cycles earlier. Assumes cyc runs from 0 while busy.
module flush_pattern #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [CNT_W-1:0] cyc,
    input  logic [CNT_W-1:0] len_ext,
    output logic             scan_bit,
    output logic             in_window,
    output logic             ref_bit
);
    logic [CNT_W-1:0] lag;

    // Pattern bit, compare window and delayed reference.
    always_comb begin
        lag       = cyc - len_ext;
        scan_bit  = busy && cyc[1];
        in_window = busy && (cyc >= len_ext);
        ref_bit   = lag[1];
    end

    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && (cyc[1:0] == 2'd2) |-> scan_bit && !$past(scan_bit));
    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scan_bit);
endmodule

// File: rtl/flush_cmp.sv
// Comparator and verdict: checks scan-out against the reference inside the
// window, latches the first failing cycle and forms the pass flag at the
// last flush edge. Cleared whenever a new flush is accepted.
module flush_cmp #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             in_window,
    input  logic             ref_bit,
    input  logic             scan_out,
    input  logic             last,
    input  logic [CNT_W-1:0] cyc,
    output logic             ok,
    output logic             bad,
    output logic [CNT_W-1:0] fail_idx
);
    logic miss;

    assign miss = in_window && (scan_out != ref_bit);

    // Sticky failure capture and end-of-flush pass verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok       <= 1'b0;
            bad      <= 1'b0;
            fail_idx <= '0;
        end else if (clear) begin
            ok       <= 1'b0;
            bad      <= 1'b0;
            fail_idx <= '0;
        end else begin
            if (miss && !bad) begin
                bad      <= 1'b1;
                fail_idx <= cyc;
            end
            if (last) ok <= !(bad || miss);
        end
    end

    p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bad && !clear |=> bad && $stable(fail_idx));
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && bad));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !ok && !bad);
endmodule

// File: rtl/scan_flush_tester.sv
// Scan chain flush tester top: holds the chain in shift mode for len+4
// clocks, feeds 0,0,1,1 and verifies the delayed stream at the output.
// Assumes scan_out is the chain's last stage, clocked by clk and shifting
// while test_ctrl is low.
module scan_flush_tester #(
    parameter int LEN_W = 6,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] chain_len,
    input  logic             scan_out,
    output logic             busy,
    output logic             done,
    output logic             test_ctrl,
    output logic             scan_in,
    output logic             chain_ok,
    output logic             chain_bad,
    output logic [CNT_W-1:0] fail_idx
);
    logic             accept;
    logic             last;
    logic [CNT_W-1:0] cyc;
    logic [CNT_W-1:0] len_ext;
    logic             in_window;
    logic             ref_bit;

    flush_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_len(chain_len),
        .busy(busy), .accept(accept), .last(last), .done(done),
        .cyc(cyc), .len_ext(len_ext)
    );

    flush_pattern #(.CNT_W(CNT_W)) u_pat (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cyc(cyc), .len_ext(len_ext),
        .scan_bit(scan_in), .in_window(in_window), .ref_bit(ref_bit)
    );

    flush_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clear(accept), .in_window(in_window),
        .ref_bit(ref_bit), .scan_out(scan_out), .last(last), .cyc(cyc),
        .ok(chain_ok), .bad(chain_bad), .fail_idx(fail_idx)
    );

    // Chain stays in shift mode exactly while a flush runs.
    assign test_ctrl = !busy;

    p_no_done_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> test_ctrl && !scan_in);
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !chain_ok && !chain_bad);
endmodule

// File: tb/scan_flush_tester_test.sv
module scan_flush_tester_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 6;
    localparam int MAXC = 64;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [LEN_W-1:0] chain_len = '0;
    logic scan_out;
    logic busy, done, test_ctrl, scan_in, chain_ok, chain_bad;
    logic [LEN_W:0] fail_idx;

    int n_checks = 0;
    int n_fails = 0;
    int cycles = 0;
    int act_len = 1;
    int fault = 0;          // 0 none, 1 stuck0, 2 stuck1, 3 invert
    logic [MAXC-1:0] sr;

    scan_flush_tester #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_len(chain_len),
        .scan_out(scan_out), .busy(busy), .done(done), .test_ctrl(test_ctrl),
        .scan_in(scan_in), .chain_ok(chain_ok), .chain_bad(chain_bad),
        .fail_idx(fail_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Chain model: loads all ones in normal mode, shifts in scan mode.
    always_ff @(posedge clk) begin
        if (test_ctrl) sr <= '1;
        else sr <= {sr[MAXC-2:0], scan_in};
    end

    always_comb begin
        case (fault)
            1: scan_out = 1'b0;
            2: scan_out = 1'b1;
            3: scan_out = ~sr[act_len-1];
            default: scan_out = sr[act_len-1];
        endcase
    end

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit good, input string req, input string what,
                       input int actual, input int expected);
        n_checks++;
        if (!good) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // Reference: first mismatching flush cycle or -1, from the chain model rules.
    function automatic int exp_first(int len, int act, int flt);
        for (int k = len; k < len + 4; k++) begin
            int j = k - act;
            int obs = (j < 0) ? 1 : ((j >> 1) & 1);
            int rf = ((k - len) >> 1) & 1;
            if (flt == 1) obs = 0;
            else if (flt == 2) obs = 1;
            else if (flt == 3) obs = 1 - obs;
            if (obs != rf) return k;
        end
        return -1;
    endfunction

    // Runs one flush. skip_start: start already issued by the caller.
    // mid_start: cycle at which a start is pulsed while busy (-1 none).
    // chain_next: raise start during the done cycle.
    task automatic run_flush(input int len, input int act, input int flt,
                             input int mid_start, input bit skip_start,
                             input bit chain_next, input string req);
        int k = 0;
        int bad_tc = 0;
        int bad_si = 0;
        int ef;
        ef = exp_first(len, act, flt);
        if (!skip_start) begin
            @(negedge clk);
            chain_len = LEN_W'(len); act_len = act; fault = flt; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (busy && k < 200) begin
            if (test_ctrl !== 1'b0) bad_tc++;
            if (scan_in !== k[1]) bad_si++;
            start = (k == mid_start);
            k++;
            @(negedge clk);
            start = 0;
        end
        chk(k == len + 4, req, "R2 flush length", k, len + 4);
        chk(bad_tc == 0, req, "R2 test_ctrl low while busy", bad_tc, 0);
        chk(bad_si == 0, req, "R3 scan_in 0011 pattern errors", bad_si, 0);
        chk(done === 1'b1 && test_ctrl === 1'b1, req, "R6 done with normal mode",
            int'(done), 1);
        chk(chain_ok === (ef < 0), req, "R4 chain_ok", int'(chain_ok), int'(ef < 0));
        chk(chain_bad === (ef >= 0), req, "R5 chain_bad", int'(chain_bad), int'(ef >= 0));
        if (ef >= 0) chk(int'(fail_idx) == ef, req, "R5 fail_idx", int'(fail_idx), ef);
        if (chain_next) begin
            start = 1;
            @(negedge clk);
            start = 0;
            chk(busy === 1'b1 && chain_bad === 1'b0 && chain_ok === 1'b0, req,
                "R8 restart on done cycle clears verdict", int'(busy), 1);
        end else begin
            @(negedge clk);
            chk(done === 1'b0, req, "R6 done single cycle", int'(done), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && test_ctrl && !scan_in && !chain_ok && !chain_bad
            && fail_idx == 0, "R1", "idle outputs in reset", int'(test_ctrl), 1);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && test_ctrl && !scan_in, "R1", "idle after reset",
            int'(busy), 0);
    endtask

    task automatic t_clean();
        run_flush(1, 1, 0, -1, 0, 0, "R4 len1");
        run_flush(5, 5, 0, -1, 0, 0, "R4 len5");
        run_flush(63, 63, 0, -1, 0, 0, "R4 len63");
    endtask

    task automatic t_faults();
        run_flush(8, 8, 1, -1, 0, 0, "R10 stuck0");
        run_flush(8, 8, 2, -1, 0, 0, "R10 stuck1");
        run_flush(8, 8, 3, -1, 0, 0, "R10 invert");
        run_flush(8, 9, 0, -1, 0, 0, "R10 long");
        run_flush(8, 7, 0, -1, 0, 0, "R10 short");
    endtask

    task automatic t_start_busy();
        run_flush(6, 6, 0, 3, 0, 0, "R7 start while busy");
        run_flush(6, 6, 1, 8, 0, 0, "R7 start while busy fail");
    endtask

    task automatic t_back_to_back();
        run_flush(4, 4, 1, -1, 0, 1, "R8 first");
        fault = 0;
        run_flush(4, 4, 0, -1, 1, 0, "R8 second");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        chain_len = 10; act_len = 10; fault = 0; start = 1;
        @(negedge clk);
        start = 0;
        repeat (5) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk(!busy && test_ctrl && !done && !chain_ok && !chain_bad, "R9",
            "abort on reset", int'(busy), 0);
        @(negedge clk);
        chk(!done && !busy, "R9", "no done after abort", int'(done), 0);
        run_flush(10, 10, 0, -1, 0, 0, "R9 after abort");
    endtask

    initial begin
        t_reset();
        t_clean();
        t_faults();
        t_start_busy();
        t_back_to_back();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule